// File: doc/BRIEF.md
# Busy-response completion synthesizer

This block sits between an SD host controller's interrupt status register and the processor. Some controllers raise their completion interrupt while the card is still holding the data line busy after a command with a busy-signalling response. The block supplies the missing busy wait itself. When a command is issued it records which of two fix-ups the command needs. It then catches the controller's premature completion bit, polls the card's data-busy indicators on a millisecond tick with a bounded wait, and produces completion or timeout status bits of its own.

Software reads interrupt status through the block and sees the raw register ORed with the synthetic bits. While a wait is in progress, the premature trigger bit is hidden from that view. The block also asks the raw register to clear the trigger bit. A write-1-to-clear from software removes matching synthetic bits and is forwarded unchanged to the raw register.

The controller FSM has five states:
- `ST_IDLE`: no fix pending.
- `ST_ARM_NODATA`: a busy response without a data phase is expected.
- `ST_ARM_STOP`: busy is expected after an automatic stop command.
- `ST_WAIT_NODATA` and `ST_WAIT_STOP`: the trigger arrived while the card was busy, and the data line is being polled.

The transitions are:
- **arm-nodata** and **arm-stop**: from `ST_IDLE` or either armed state, on a qualifying command write.
- **fire-clear**: from an armed state back to `ST_IDLE`, when the trigger arrives and the card is idle.
- **fire-wait**: from an armed state to the matching wait state, when the trigger arrives and the card is busy.
- **release** and **expire**: from a wait state back to `ST_IDLE`, at a tick where busy has gone or where the deadline is reached.

Top module: `bsy_completion_synth`

## Requirements
- R1: After reset the block is in `ST_IDLE`. Merged status equals raw status, no raw clear is requested, and the forced response enable is low.
- R2: A command write with `cmd_data`=0 and `cmd_resp`=2'b11 (short response with busy) arms no-data mode. While that mode is armed or waiting, `force_resp_en` is high, and response-complete (bit 0) is treated as enabled for the interrupt.
- R3: A command write with `cmd_data`=1, while `mode_auto_stop` and `mode_multi` are both 1, arms stop mode. In this mode the trigger is transfer-complete (bit 1), and a release synthesizes bit 1 only.
- R4: Other command writes arm nothing. With no mode armed, raw status bits pass through unchanged, and no clear is requested.
- R5: If the trigger bit is seen while the card is idle, the synthetic bits appear on the next cycle. These are bit 1, plus bit 0 in no-data mode. The mode returns to none.
- R6: If the trigger bit is seen while the card is busy, that same cycle requests a raw clear of the trigger bit. The trigger bit is then masked out of merged status until the wait resolves.
- R7: The card is busy while `busy_active` or `busy_inhibit` is 1. Busy is resampled once per tick of `TICK_CYCLES` cycles, and release happens only at a tick where both are 0.
- R8: If the card is still busy at tick number `TIMEOUT_TICKS`, data-timeout (bit 20) is synthesized and the mode returns to none. It is never synthesized earlier.
- R9: Synthetic bits are ORed into `merged_status`. A status clear write removes the synthetic bits set in `clr_mask` and is forwarded on `raw_clr_valid`/`raw_clr_mask` in the same cycle.
- R10: `irq` is high exactly when some merged status bit is set in the effective signal enable mask.
- R11: Command writes made during a wait are ignored. The pending mode remains the one that started the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command flags write strobe |
| cmd_data | input | 1 | Command has a data phase |
| cmd_resp | input | 2 | Response type; 2'b11 = short with busy |
| mode_auto_stop | input | 1 | Transfer mode: automatic stop command enabled |
| mode_multi | input | 1 | Transfer mode: multi-block transfer |
| raw_status | input | STATUS_W | Controller's raw interrupt status |
| sig_en | input | STATUS_W | Signal enable mask |
| busy_active | input | 1 | Present state: data line active |
| busy_inhibit | input | 1 | Present state: data inhibit |
| clr_wr | input | 1 | Status write-1-to-clear strobe |
| clr_mask | input | STATUS_W | Bits to clear |
| merged_status | output | STATUS_W | Status as seen by software |
| raw_clr_valid | output | 1 | Clear request to the raw register |
| raw_clr_mask | output | STATUS_W | Bits to clear in the raw register |
| force_resp_en | output | 1 | Response-complete must be enabled in both enable masks |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `TICK_CYCLES`=4 and `TIMEOUT_TICKS`=5, so a complete timeout takes only twenty cycles. This short window lets one run reach the timeout path and the release path in both modes. It also lets a release land several ticks into a wait, after `busy_active` falls while `busy_inhibit` is still held. With these values the bench can also issue a command write inside a wait, and sample just before and just after the deadline tick.

// File: rtl/bsy_pkg.sv
package bsy_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM_NODATA,
        ST_ARM_STOP,
        ST_WAIT_NODATA,
        ST_WAIT_STOP
    } bsy_state_e;

    localparam int RESP_BIT = 0;
    localparam int XFER_BIT = 1;
    localparam int DTMO_BIT = 20;
    localparam logic [1:0] RESP_SHORT_BUSY = 2'b11;
endpackage

// File: rtl/bsy_tick_timer.sv
module bsy_tick_timer #(
    parameter int TICK_CYCLES   = 100000,
    parameter int TIMEOUT_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick,
    output logic deadline
);
    localparam int CW = $clog2(TICK_CYCLES + 1);
    localparam int KW = $clog2(TIMEOUT_TICKS + 1);

    logic [CW-1:0] cyc_q;
    logic [KW-1:0] ticks_q;

    assign tick     = run && (cyc_q == CW'(TICK_CYCLES - 1));
    assign deadline = tick && (ticks_q == KW'(TIMEOUT_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            ticks_q <= '0;
        end else if (!run) begin
            cyc_q   <= '0;
            ticks_q <= '0;
        end else if (tick) begin
            cyc_q   <= '0;
            ticks_q <= ticks_q + 1'b1;
        end else begin
            cyc_q   <= cyc_q + 1'b1;
        end
    end

    // R7
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (TICK_CYCLES > 1 && tick) |=> !tick);
endmodule

// File: rtl/bsy_ctrl.sv
module bsy_ctrl
    import bsy_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       cmd_data,
    input  logic [1:0] cmd_resp,
    input  logic       mode_auto_stop,
    input  logic       mode_multi,
    input  logic       raw_resp,
    input  logic       raw_xfer,
    input  logic       busy,
    input  logic       tick,
    input  logic       deadline,
    output logic       timer_run,
    output logic       hold_resp,
    output logic       hold_xfer,
    output logic       clr_resp,
    output logic       clr_xfer,
    output logic       set_resp,
    output logic       set_xfer,
    output logic       set_tmo,
    output logic       force_resp
);
    bsy_state_e state_q, state_d;
    logic arm_nd, arm_st;

    assign arm_nd = cmd_wr && !cmd_data && (cmd_resp == RESP_SHORT_BUSY);
    assign arm_st = cmd_wr && cmd_data && mode_auto_stop && mode_multi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ARM_NODATA, ST_ARM_STOP: begin
                if (state_q == ST_ARM_NODATA && raw_resp)
                    state_d = busy ? ST_WAIT_NODATA : ST_IDLE;
                else if (state_q == ST_ARM_STOP && raw_xfer)
                    state_d = busy ? ST_WAIT_STOP : ST_IDLE;
                else if (arm_nd)
                    state_d = ST_ARM_NODATA;
                else if (arm_st)
                    state_d = ST_ARM_STOP;
            end
            ST_WAIT_NODATA, ST_WAIT_STOP: begin
                if (tick && (!busy || deadline)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        hold_resp  = 1'b0;
        hold_xfer  = 1'b0;
        clr_resp   = 1'b0;
        clr_xfer   = 1'b0;
        set_resp   = 1'b0;
        set_xfer   = 1'b0;
        set_tmo    = 1'b0;
        force_resp = (state_q == ST_ARM_NODATA) || (state_q == ST_WAIT_NODATA);
        timer_run  = (state_q == ST_WAIT_NODATA) || (state_q == ST_WAIT_STOP);
        unique case (state_q)
            ST_ARM_NODATA: if (raw_resp) begin
                if (busy) begin
                    hold_resp = 1'b1;
                    clr_resp  = 1'b1;
                end else begin
                    set_xfer  = 1'b1;
                    set_resp  = 1'b1;
                end
            end
            ST_ARM_STOP: if (raw_xfer) begin
                if (busy) begin
                    hold_xfer = 1'b1;
                    clr_xfer  = 1'b1;
                end else begin
                    set_xfer  = 1'b1;
                end
            end
            ST_WAIT_NODATA: begin
                hold_resp = 1'b1;
                if (tick && !busy) begin
                    set_xfer = 1'b1;
                    set_resp = 1'b1;
                end else if (deadline) begin
                    set_tmo  = 1'b1;
                end
            end
            ST_WAIT_STOP: begin
                hold_xfer = 1'b1;
                if (tick && !busy)  set_xfer = 1'b1;
                else if (deadline)  set_tmo  = 1'b1;
            end
            default: ;
        endcase
    end

    // R5
    release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_xfer |-> !busy);
    // R8
    timeout_deadline_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_tmo |-> (deadline && busy));
    // R6
    clear_enters_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_resp || clr_xfer) |=> timer_run);
    // R11
    wait_holds_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_run && !tick) |=> (state_q == $past(state_q)));
endmodule

// File: rtl/bsy_status_merge.sv
module bsy_status_merge
    import bsy_pkg::*;
#(
    parameter int STATUS_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] raw_status,
    input  logic [STATUS_W-1:0] sig_en,
    input  logic                clr_wr,
    input  logic [STATUS_W-1:0] clr_mask,
    input  logic                hold_resp,
    input  logic                hold_xfer,
    input  logic                clr_resp,
    input  logic                clr_xfer,
    input  logic                set_resp,
    input  logic                set_xfer,
    input  logic                set_tmo,
    input  logic                force_resp,
    output logic [STATUS_W-1:0] merged_status,
    output logic                raw_clr_valid,
    output logic [STATUS_W-1:0] raw_clr_mask,
    output logic                irq
);
    localparam logic [STATUS_W-1:0] RESP_V = STATUS_W'(1) << RESP_BIT;
    localparam logic [STATUS_W-1:0] XFER_V = STATUS_W'(1) << XFER_BIT;
    localparam logic [STATUS_W-1:0] DTMO_V = STATUS_W'(1) << DTMO_BIT;

    logic [STATUS_W-1:0] synth_q, set_v, hold_v, cpu_clr_v, fsm_clr_v, en_v;

    assign set_v     = (set_resp ? RESP_V : '0) | (set_xfer ? XFER_V : '0) |
                       (set_tmo ? DTMO_V : '0);
    assign hold_v    = (hold_resp ? RESP_V : '0) | (hold_xfer ? XFER_V : '0);
    assign fsm_clr_v = (clr_resp ? RESP_V : '0) | (clr_xfer ? XFER_V : '0);
    assign cpu_clr_v = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) synth_q <= '0;
        else        synth_q <= (synth_q & ~cpu_clr_v) | set_v;
    end

    assign merged_status = (raw_status & ~hold_v) | synth_q;
    assign raw_clr_mask  = cpu_clr_v | fsm_clr_v;
    assign raw_clr_valid = clr_wr || clr_resp || clr_xfer;
    assign en_v          = sig_en | (force_resp ? RESP_V : '0);
    assign irq           = |(merged_status & en_v);

    // R9
    synth_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[XFER_BIT] && !set_xfer) |=> !synth_q[XFER_BIT]);
    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (merged_status != '0));
endmodule

// File: rtl/bsy_completion_synth.sv
module bsy_completion_synth
    import bsy_pkg::*;
#(
    parameter int STATUS_W      = 32,
    parameter int TICK_CYCLES   = 100000,
    parameter int TIMEOUT_TICKS = 250
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wr,
    input  logic                cmd_data,
    input  logic [1:0]          cmd_resp,
    input  logic                mode_auto_stop,
    input  logic                mode_multi,
    input  logic [STATUS_W-1:0] raw_status,
    input  logic [STATUS_W-1:0] sig_en,
    input  logic                busy_active,
    input  logic                busy_inhibit,
    input  logic                clr_wr,
    input  logic [STATUS_W-1:0] clr_mask,
    output logic [STATUS_W-1:0] merged_status,
    output logic                raw_clr_valid,
    output logic [STATUS_W-1:0] raw_clr_mask,
    output logic                force_resp_en,
    output logic                irq
);
    logic busy, tick, deadline, timer_run;
    logic hold_resp, hold_xfer, clr_resp, clr_xfer, set_resp, set_xfer, set_tmo;

    assign busy = busy_active || busy_inhibit;

    bsy_tick_timer #(.TICK_CYCLES(TICK_CYCLES), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(timer_run), .tick(tick), .deadline(deadline)
    );

    bsy_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .cmd_resp(cmd_resp), .mode_auto_stop(mode_auto_stop), .mode_multi(mode_multi),
        .raw_resp(raw_status[RESP_BIT]), .raw_xfer(raw_status[XFER_BIT]),
        .busy(busy), .tick(tick), .deadline(deadline), .timer_run(timer_run),
        .hold_resp(hold_resp), .hold_xfer(hold_xfer), .clr_resp(clr_resp),
        .clr_xfer(clr_xfer), .set_resp(set_resp), .set_xfer(set_xfer),
        .set_tmo(set_tmo), .force_resp(force_resp_en)
    );

    bsy_status_merge #(.STATUS_W(STATUS_W)) u_merge (
        .clk(clk), .rst_n(rst_n), .raw_status(raw_status), .sig_en(sig_en),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .hold_resp(hold_resp),
        .hold_xfer(hold_xfer), .clr_resp(clr_resp), .clr_xfer(clr_xfer),
        .set_resp(set_resp), .set_xfer(set_xfer), .set_tmo(set_tmo),
        .force_resp(force_resp_en), .merged_status(merged_status),
        .raw_clr_valid(raw_clr_valid), .raw_clr_mask(raw_clr_mask), .irq(irq)
    );
endmodule

// File: tb/bsy_completion_synth_test.sv
module bsy_completion_synth_test;
    localparam int W  = 32;
    localparam int TC = 4;
    localparam int TO = 5;
    localparam logic [W-1:0] RESP = 32'h0000_0001;
    localparam logic [W-1:0] XFER = 32'h0000_0002;
    localparam logic [W-1:0] TMO  = 32'h0010_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_wr = 0, cmd_data = 0, mode_auto_stop = 0, mode_multi = 0;
    logic [1:0] cmd_resp = 2'b00;
    logic [W-1:0] raw_status = '0, sig_en = '0, clr_mask = '0;
    logic busy_active = 0, busy_inhibit = 0, clr_wr = 0;
    logic [W-1:0] merged_status, raw_clr_mask;
    logic raw_clr_valid, force_resp_en, irq;

    bsy_completion_synth #(.STATUS_W(W), .TICK_CYCLES(TC), .TIMEOUT_TICKS(TO)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .cmd_resp(cmd_resp), .mode_auto_stop(mode_auto_stop), .mode_multi(mode_multi),
        .raw_status(raw_status), .sig_en(sig_en), .busy_active(busy_active),
        .busy_inhibit(busy_inhibit), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .merged_status(merged_status), .raw_clr_valid(raw_clr_valid),
        .raw_clr_mask(raw_clr_mask), .force_resp_en(force_resp_en), .irq(irq)
    );

    always #4 clk = ~clk;

    int checks = 0, fails = 0;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Behavioural reference: mode 0 none, 1 no-data, 2 stop
    int m_mode = 0, m_wcyc = 0;
    bit m_wait = 0;
    logic [W-1:0] m_synth = '0, e_trig, e_hide, e_merged, e_clrm, e_nsynth;
    logic e_busy, e_fire, e_irq;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_wait = 0; m_wcyc = 0; m_synth = '0;
        end else begin
            e_busy = busy_active | busy_inhibit;
            e_trig = (m_mode == 1) ? RESP : (m_mode == 2) ? XFER : '0;
            e_fire = !m_wait && ((raw_status & e_trig) != '0);
            e_hide = (m_wait || (e_fire && e_busy)) ? e_trig : '0;
            e_merged = (raw_status & ~e_hide) | m_synth;
            e_clrm = (clr_wr ? clr_mask : '0) | ((e_fire && e_busy) ? e_trig : '0);
            e_irq = |(e_merged & (sig_en | ((m_mode == 1) ? RESP : '0)));
            chk("R9 merged", merged_status, e_merged);
            chk("R6 clear mask", raw_clr_mask, e_clrm);
            chk("R6 clear valid", {31'd0, raw_clr_valid}, {31'd0, (clr_wr || (e_fire && e_busy))});
            chk("R2 force", {31'd0, force_resp_en}, {31'd0, (m_mode == 1)});
            chk("R10 irq", {31'd0, irq}, {31'd0, e_irq});
            e_nsynth = m_synth & ~(clr_wr ? clr_mask : '0);
            if (m_wait) begin
                m_wcyc++;
                if (m_wcyc % TC == 0) begin
                    if (!e_busy) begin
                        e_nsynth |= XFER | ((m_mode == 1) ? RESP : '0);
                        m_mode = 0; m_wait = 0;
                    end else if (m_wcyc / TC == TO) begin
                        e_nsynth |= TMO;
                        m_mode = 0; m_wait = 0;
                    end
                end
            end else if (e_fire) begin
                if (!e_busy) begin
                    e_nsynth |= XFER | ((m_mode == 1) ? RESP : '0);
                    m_mode = 0;
                end else begin
                    m_wait = 1; m_wcyc = 0;
                end
            end else if (cmd_wr) begin
                if (!cmd_data && cmd_resp == 2'b11) m_mode = 1;
                else if (cmd_data && mode_auto_stop && mode_multi) m_mode = 2;
            end
            m_synth = e_nsynth;
        end
    end

    task automatic summary;
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1;
        raw_status = RESP;
        @(negedge clk);
        chk("R1 merged after reset", merged_status, RESP);
        chk("R1 no clear", {31'd0, raw_clr_valid}, '0);
        chk("R1 force low", {31'd0, force_resp_en}, '0);
        cyc(1); raw_status = '0;

        // R2: arm no-data mode
        cmd_wr = 1; cmd_data = 0; cmd_resp = 2'b11;
        cyc(1); cmd_wr = 0;
        @(negedge clk);
        chk("R2 force after arm", {31'd0, force_resp_en}, 32'd1);

        // R5: trigger with idle card
        cyc(1); raw_status = RESP;
        @(negedge clk);
        chk("R5 no clear when idle", {31'd0, raw_clr_valid}, '0);
        chk("R10 forced resp enable", {31'd0, irq}, 32'd1);
        cyc(1); raw_status = '0; sig_en = XFER;
        @(negedge clk);
        chk("R5 synth resp+xfer", merged_status, RESP | XFER);
        chk("R5 mode none", {31'd0, force_resp_en}, '0);
        chk("R10 irq on enabled bit", {31'd0, irq}, 32'd1);

        // R9: clear write
        cyc(1); clr_wr = 1; clr_mask = XFER;
        @(negedge clk);
        chk("R9 clear forwarded", raw_clr_mask, XFER);
        cyc(1); clr_wr = 0;
        @(negedge clk);
        chk("R9 synth bit cleared", merged_status, RESP);
        chk("R10 irq dropped", {31'd0, irq}, '0);
        cyc(1); clr_wr = 1; clr_mask = RESP;
        cyc(1); clr_wr = 0; sig_en = '0;

        // R3 stop mode, R6 hold, R7 busy sources
        cmd_wr = 1; cmd_data = 1; mode_auto_stop = 1; mode_multi = 1;
        cyc(1); cmd_wr = 0;
        busy_active = 1; raw_status = XFER;
        @(negedge clk);
        chk("R6 clear requested", raw_clr_mask, XFER);
        chk("R6 trigger hidden", merged_status, '0);
        cyc(1);
        @(negedge clk);
        chk("R6 hidden while waiting", merged_status, '0);
        cyc(1); raw_status = '0; busy_active = 0; busy_inhibit = 1;
        cyc(2 * TC);
        @(negedge clk);
        chk("R7 inhibit keeps busy", merged_status, '0);
        busy_inhibit = 0;
        cyc(TC);
        @(negedge clk);
        chk("R3 release xfer only", merged_status, XFER);
        cyc(1); clr_wr = 1; clr_mask = XFER;
        cyc(1); clr_wr = 0; mode_auto_stop = 0; mode_multi = 0;

        // R8 timeout, R11 command during wait
        cmd_wr = 1; cmd_data = 0; cmd_resp = 2'b11;
        cyc(1); cmd_wr = 0; busy_inhibit = 1; raw_status = RESP;
        cyc(1); raw_status = '0;
        cmd_wr = 1; cmd_data = 1; mode_auto_stop = 1; mode_multi = 1;
        cyc(1); cmd_wr = 0;
        @(negedge clk);
        chk("R11 mode kept", {31'd0, force_resp_en}, 32'd1);
        cyc(TO * TC - 3);
        @(negedge clk);
        chk("R8 not before deadline", merged_status, '0);
        cyc(3); sig_en = TMO;
        @(negedge clk);
        chk("R8 timeout bit", merged_status, TMO);
        chk("R10 irq on timeout", {31'd0, irq}, 32'd1);
        cyc(1); raw_status = XFER;
        @(negedge clk);
        chk("R11 no stop arm", {31'd0, raw_clr_valid}, '0);
        cyc(1); raw_status = '0; clr_wr = 1; clr_mask = TMO;
        cyc(1); clr_wr = 0; busy_inhibit = 0; sig_en = '0;
        mode_auto_stop = 0; mode_multi = 0;

        // R4 non-arming commands
        cmd_wr = 1; cmd_data = 0; cmd_resp = 2'b10;
        cyc(1); cmd_wr = 0; raw_status = RESP; busy_active = 1;
        @(negedge clk);
        chk("R4 resp passes", merged_status, RESP);
        cyc(1); raw_status = '0;
        cmd_wr = 1; cmd_data = 1; mode_auto_stop = 1;
        cyc(1); cmd_wr = 0; raw_status = XFER;
        @(negedge clk);
        chk("R4 xfer passes", merged_status, XFER);
        chk("R4 no clear", {31'd0, raw_clr_valid}, '0);
        cyc(1); raw_status = '0; busy_active = 0;
        @(negedge clk);
        chk("R4 nothing synthesized", merged_status, '0);
        cyc(2);
        summary();
        $finish;
    end
endmodule